// File: doc/BRIEF.md
# Soft-Transition Logarithmic Input Attenuator

This block scales a two-channel (left/right) stream of signed converter samples by a per-channel gain taken from a logarithmic scale. Each channel has a 7-bit attenuation code. The code comes in through a volume register port that is shared with an analog gain stage. A write with bit 7 clear belongs to this block. A write with bit 7 set belongs to the analog stage, and this block ignores it. Code 127 is unity gain. Each code below that is 0.75 dB quieter. Code 0 is mute.

A new code never makes the gain jump. The gain walks from its present value to the new target in 29 equal linear steps, one step per accepted sample pair. If a further write arrives while a walk is in progress, a new walk starts from wherever the gain stands at that moment.

Samples enter and leave through valid/ready handshakes. Each side follows the usual rule: a transfer happens in a cycle where valid and ready are both high.
- On the output, a valid result stays on the pins unchanged until the consumer takes it.
- The input is ready whenever the single output register is empty or is being emptied in the same cycle.
- Back-pressure therefore reaches the producer in the same cycle, and no data is dropped.

Top module: `lia_top`

## Requirements
- R1: After reset `m_valid` is 0, `s_ready` is 1, and both channels sit at unity gain (code 127) with no walk in progress.
- R2: A write with `reg_we`=1 and `reg_wdata[7]`=0 sets the target code of the channel picked by `reg_sel` (0 = left, 1 = right) to `reg_wdata[6:0]`. A write with `reg_wdata[7]`=1 changes neither channel.
- R3: For code c>0, let a = 127−c. The target gain in Q1.15 is round(32768·2^(−(a mod 8)/8)) shifted right by floor(a/8). Code 0 has gain 0.
- R4: After a write, the k-th accepted sample pair (k = 1..29) sets the gain to S + trunc((T−S)·k/29). S is the gain at the write and T is the target; trunc rounds toward zero. After the 29th pair the gain equals T and stays there.
- R5: An accepted sample is scaled by the gain in force before that cycle's step. If a write and an accepted sample fall in the same cycle, the sample uses the present gain, the walk restarts from that gain, and no step is taken in that cycle.
- R6: A write during a walk starts a new walk. Its start value S is the gain reached so far, not the old target.
- R7: The output is floor((x·g + 16384)/32768), saturated to the signed sample width. Unity gain passes a sample through unchanged. Once a walk to code 0 has completed, every output is exactly 0.
- R8: `s_ready` = !`m_valid` or `m_ready`. An accepted input pair appears on the outputs one cycle later. A result held with `m_ready`=0 keeps `m_valid` high and the data stable. No pair is lost or repeated.
- R9: The two channels keep separate codes, gains and walks. A write to one channel does not alter the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_we | input | 1 | Volume register write strobe |
| reg_sel | input | 1 | Channel of the write: 0 left, 1 right |
| reg_wdata | input | 8 | Bit 7 selects the stage (0 = this block); bits 6:0 are the code |
| s_valid | input | 1 | Input sample pair valid |
| s_ready | output | 1 | Input sample pair can be taken |
| s_data_l | input | DW | Left input sample, signed |
| s_data_r | input | DW | Right input sample, signed |
| m_valid | output | 1 | Output sample pair valid |
| m_ready | input | 1 | Consumer takes the output pair |
| m_data_l | output | DW | Left attenuated sample, signed |
| m_data_r | output | DW | Right attenuated sample, signed |

## Verification
Two functions can fall in the same cycle:
- A register write and an accepted sample. The bench forces this with a directed step that raises `reg_we` and `s_valid` together in the middle of a walk. Random traffic, where writes come about one cycle in eight, repeats it many times.
- A stalled output and a newly offered input. The bench holds `m_ready` low on random cycles.

The bench judges the first case against a model built from R5: the colliding sample carries the old gain, and the next sample carries the restarted walk's first step. For the second case it checks that the held output does not move, and that every accepted pair comes out once, in order, matching R7's arithmetic.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int NCH       = 2;
  localparam int CODE_W    = 7;
  localparam int GAIN_FRAC = 15;
  localparam int GAIN_W    = GAIN_FRAC + 1;
  localparam int UNITY     = 1 << GAIN_FRAC;
  localparam int OCTAVE    = 8;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [GAIN_W-1:0] gain_t;

  // Log law: 0.75 dB per code, eight codes per halving; code 0 mutes.
  function automatic gain_t code_to_gain(input code_t c);
    int a;
    int m;
    if (c == '0) return '0;
    a = ((1 << CODE_W) - 1) - int'(c);
    case (a % OCTAVE)
      0:       m = 32768;
      1:       m = 30048;
      2:       m = 27554;
      3:       m = 25268;
      4:       m = 23170;
      5:       m = 21247;
      6:       m = 19484;
      default: m = 17867;
    endcase
    return gain_t'(m >>> (a / OCTAVE));
  endfunction
endpackage

// File: rtl/lia_ramp.sv
module lia_ramp
  import lia_pkg::*;
#(
  parameter int RAMP_STEPS = 29,
  parameter int CNT_W      = $clog2(RAMP_STEPS + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  code_t load_code,
  input  logic  adv,
  output gain_t gain
);
  gain_t            gain_q, start_q, tgt_q, next_gain;
  logic [CNT_W-1:0] cnt_q;
  logic             idle;
  int               diff, k;

  assign idle = (cnt_q == CNT_W'(RAMP_STEPS));
  assign gain = gain_q;

  always_comb begin
    diff      = int'(tgt_q) - int'(start_q);
    k         = int'(cnt_q) + 1;
    next_gain = gain_t'(int'(start_q) + (diff * k) / RAMP_STEPS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q  <= gain_t'(UNITY);
      start_q <= gain_t'(UNITY);
      tgt_q   <= gain_t'(UNITY);
      cnt_q   <= CNT_W'(RAMP_STEPS);
    end else if (load) begin
      tgt_q   <= code_to_gain(load_code);
      start_q <= gain_q;
      cnt_q   <= '0;
    end else if (adv && !idle) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      gain_q <= next_gain;
    end
  end

  assert_settled_on_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> gain_q == tgt_q);
  assert_gain_within_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> ((gain_q >= start_q && gain_q <= tgt_q) || (gain_q <= start_q && gain_q >= tgt_q)));
  assert_restart_keeps_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (gain_q == $past(gain_q) && cnt_q == '0));
  assert_step_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !load |=> $stable(gain_q));
endmodule

// File: rtl/lia_scale.sv
module lia_scale
  import lia_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = DW + GAIN_W + 1
) (
  input  logic signed [DW-1:0] sample,
  input  gain_t                gain,
  output logic signed [DW-1:0] result
);
  logic signed [PW-1:0] prod, rnd, shifted;
  logic                 fits;

  always_comb begin
    prod    = PW'(sample) * PW'($signed({1'b0, gain}));
    rnd     = prod + (PW'(1) <<< (GAIN_FRAC - 1));
    shifted = rnd >>> GAIN_FRAC;
    fits    = (&shifted[PW-1:DW-1]) || !(|shifted[PW-1:DW-1]);
    if (fits)             result = shifted[DW-1:0];
    else if (shifted[PW-1]) result = {1'b1, {(DW-1){1'b0}}};
    else                  result = {1'b0, {(DW-1){1'b1}}};
  end
endmodule

// File: rtl/lia_top.sv
module lia_top
  import lia_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RAMP_STEPS = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data_l,
  input  logic [DW-1:0] s_data_r,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data_l,
  output logic [DW-1:0] m_data_r
);
  logic                 accept, m_valid_q;
  logic signed [DW-1:0] in_w  [NCH];
  logic signed [DW-1:0] out_w [NCH];
  logic signed [DW-1:0] m_data_q [NCH];
  gain_t                gain_w [NCH];

  assign s_ready = !m_valid_q || m_ready;
  assign accept  = s_valid && s_ready;
  assign m_valid = m_valid_q;
  assign in_w[0] = s_data_l;
  assign in_w[1] = s_data_r;
  assign m_data_l = m_data_q[0];
  assign m_data_r = m_data_q[1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic load;
    assign load = reg_we && !reg_wdata[7] && (int'(reg_sel) == ch);

    lia_ramp #(.RAMP_STEPS(RAMP_STEPS)) ramp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_code (reg_wdata[CODE_W-1:0]),
      .adv       (accept),
      .gain      (gain_w[ch])
    );

    lia_scale #(.DW(DW)) scale_i (
      .sample (in_w[ch]),
      .gain   (gain_w[ch]),
      .result (out_w[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid_q <= 1'b0;
      for (int i = 0; i < NCH; i++) m_data_q[i] <= '0;
    end else if (accept) begin
      m_valid_q <= 1'b1;
      for (int i = 0; i < NCH; i++) m_data_q[i] <= out_w[i];
    end else if (m_ready) begin
      m_valid_q <= 1'b0;
    end
  end

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data_l) && $stable(m_data_r));
  assert_upper_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_wdata[7] && !accept |=> $stable(gain_w[0]) && $stable(gain_w[1]));
  assert_unity_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && gain_w[0] == gain_t'(UNITY) |=> m_data_l == $past(s_data_l));
  assert_mute_is_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && gain_w[1] == '0 |=> m_data_r == '0);
endmodule

// File: tb/lia_top_tb_top.sv
`timescale 1ns/1ps
module lia_top_tb_top;
  localparam int DW = 16;
  localparam int STEPS = 29;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic s_valid = 0, m_ready = 0;
  logic [DW-1:0] s_data_l = 0, s_data_r = 0;
  logic s_ready, m_valid;
  logic [DW-1:0] m_data_l, m_data_r;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  int cur[2], st[2], tg[2], cnt[2];
  int ql[$], qr[$];
  bit hold = 0;
  logic [DW-1:0] hold_l, hold_r;

  always #2.5 clk = ~clk;

  lia_top #(.DW(DW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int law(input int c);
    int a, mi;
    if (c == 0) return 0;
    a  = 127 - c;
    mi = $rtoi(32768.0 * (2.0 ** (-real'(a % 8) / 8.0)) + 0.5);
    return mi >> (a / 8);
  endfunction

  function automatic int scale(input int s, input int g);
    longint q;
    q = (longint'(s) * g + 16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic step(input bit we, input bit sel, input logic [7:0] wd,
                      input bit sv, input int l, input int r, input bit mr);
    bit acc;
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    s_valid = sv; s_data_l = DW'(l); s_data_r = DW'(r); m_ready = mr;
    #1;
    chk(s_ready == (!m_valid || m_ready), "R8", "s_ready", s_ready, !m_valid || m_ready);
    if (hold) begin
      chk(m_valid && m_data_l == hold_l && m_data_r == hold_r, "R8", "held data",
          longint'($signed(m_data_l)), longint'($signed(hold_l)));
    end
    if (m_valid && m_ready) begin
      if (ql.size() == 0) chk(0, "R8", "unexpected output", 1, 0);
      else begin
        int el = ql.pop_front();
        int er = qr.pop_front();
        chk(int'($signed(m_data_l)) == el, tag, "left data", longint'($signed(m_data_l)), el);
        chk(int'($signed(m_data_r)) == er, {tag, " R9"}, "right data", longint'($signed(m_data_r)), er);
      end
    end
    acc = s_valid && s_ready;
    if (acc) begin
      ql.push_back(scale(int'($signed(s_data_l)), cur[0]));
      qr.push_back(scale(int'($signed(s_data_r)), cur[1]));
    end
    for (int c = 0; c < 2; c++) begin
      if (we && !wd[7] && int'(sel) == c) begin
        st[c] = cur[c]; tg[c] = law(int'(wd[6:0])); cnt[c] = 0;
      end else if (acc && cnt[c] < STEPS) begin
        cnt[c]++;
        cur[c] = st[c] + ((tg[c] - st[c]) * cnt[c]) / STEPS;
      end
    end
    hold = m_valid && !m_ready; hold_l = m_data_l; hold_r = m_data_r;
  endtask

  task automatic feed(input int n, input int l, input int r);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 1, l, r, 1);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R8", "watchdog cycles", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd24680));
    for (int c = 0; c < 2; c++) begin cur[c] = 32768; st[c] = 32768; tg[c] = 32768; cnt[c] = STEPS; end
    repeat (3) @(negedge clk);
    #1;
    chk(m_valid == 0, "R1", "m_valid in reset", m_valid, 0);
    chk(s_ready == 1, "R1", "s_ready in reset", s_ready, 1);
    @(negedge clk); rst_n = 1;
    tag = "R1";  feed(2, 32767, -32768);
    tag = "R7";  feed(2, -12345, 777);
    tag = "R3";  step(1, 0, 8'd100, 0, 0, 0, 1); feed(31, 20000, -20000);
    step(1, 1, 8'd37, 1, 1000, 1000, 1); feed(31, 32767, -32767);
    tag = "R2";  step(1, 0, 8'h80, 0, 0, 0, 1); step(1, 1, 8'hFF, 0, 0, 0, 1); feed(5, 30000, 30000);
    tag = "R6";  step(1, 0, 8'd127, 0, 0, 0, 1); feed(10, 25000, 25000);
    step(1, 0, 8'd10, 1, 25000, 25000, 1); feed(8, 25000, 25000);
    tag = "R5";  step(1, 0, 8'd90, 1, 31000, 31000, 1); feed(33, 31000, -31000);
    tag = "R7";  step(1, 1, 8'd0, 0, 0, 0, 1); feed(30, 1234, 32767);
    feed(3, -32768, -32768);
    chk(cur[1] == 0, "R7", "model mute gain", cur[1], 0);
    tag = "R8";
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1, i * 700, -i * 500, i % 3 == 0);
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      bit we = ($urandom % 8) == 0;
      step(we, 1'($urandom), 8'($urandom), ($urandom % 4) != 0,
           int'($signed(16'($urandom))), int'($signed(16'($urandom))), ($urandom % 4) != 0);
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 1);
    chk(ql.size() == 0, "R8", "pending outputs after drain", ql.size(), 0);
    finish_run();
  end
endmodule